// File: doc/BRIEF.md
# PHY PLL Configuration Sequencer

This block brings up the clock generator of a serial-display PHY by issuing an ordered series of writes to the three configuration registers of the PLL. The operands are computed elsewhere and arrive as plain inputs: the feedback multiplier M, the input divider N, the VCO and proportional charge-pump codes, the high-speed frequency-range code, and the configuration clock frequency in MHz. A configure request captures these operands. The block then selects the generated clock and pulses the shadow-clear bit. Next it loads the control, divider and charge-pump words and enables the reference clock. After a settling wait it raises the PLL update bit, holds it, and removes it again through a read-modify-write.

Two shorter sequences write zero to all three registers. One of them is the initialisation clear. The other is a power-off, which also drops the reference-clock enable. Every wait is counted in system-clock cycles and set by a parameter. The register writes leave through a valid/ready port. When ready is low, the block holds address and data and waits, so a slow register bus only stretches the sequence and never shortens a wait. The requests, busy and done are plain level or pulse pins.

Top module: `pll_cfg_seq`

## Requirements
- R1: While reset is held, and after it is released with no request, wr_valid, busy, done and ref_clk_en are all 0.
- R2: A configure request produces exactly eight writes. The first three go to the control address with data 0x00000040, then 0x00040040, then 0x00000040. Clock-select code 1 sits in bits 7:6 and shadow-clear is bit 18.
- R3: The fourth write goes to the control address with 0x40, plus ((cfg_clk_mhz-17)*4) in bits 5:0, plus hsrange_code in bits 14:8. The fifth goes to the divider address with M-2 in bits 9:0, N-1 in bits 13:10, vco_code in 19:14, prop_code in 25:20 and 0 in bits 31:26. The sixth goes to the charge-pump address with data 0x00000041, which is GMP 1 in bits 1:0 and bias 0x10 in bits 8:2.
- R4: At least SEL_WAIT+1 cycles separate the accepts of writes one and two. At least CLR_WAIT+1 cycles separate the accepts of writes two and three. With ready held high, the spacing is exactly these values.
- R5: ref_clk_en rises on the accept of write six. Write seven is accepted at least REF_WAIT+1 cycles later, exactly that many with ready held high.
- R6: Write seven is the last control word with bit 17 set. Write eight is the same word with bit 17 cleared and all other bits unchanged. These two writes are at least UPD_WAIT+1 cycles apart, exactly that many with ready held high.
- R7: A write transfers on a cycle where both wr_valid and wr_ready are high. While wr_valid is high and wr_ready is low, wr_valid, wr_addr and wr_data hold their values.
- R8: busy is high from the cycle after a request is taken until the final write is accepted. done is high for exactly one cycle, in the cycle after the final accept, and busy is low in that cycle.
- R9: The operands are captured when a configure request is taken. Changing them later, or raising any request while busy is high, has no effect on the writes.
- R10: A clear request writes 0 to the control, divider and charge-pump addresses, in that order, and leaves ref_clk_en unchanged.
- R11: A power-off request writes the same three zero words and then lowers ref_clk_en, so it is 0 when done pulses.
- R12: If requests coincide in an idle cycle, power-off wins over clear, and clear wins over configure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Configure request, taken when idle |
| clear_req | input | 1 | Clear-all request, taken when idle |
| pwroff_req | input | 1 | Power-off request, taken when idle |
| m_val | input | 10 | PLL feedback multiplier M |
| n_val | input | 5 | PLL input divider N (1 to 16) |
| vco_code | input | 6 | VCO range control code |
| prop_code | input | 6 | Proportional charge-pump code |
| hsrange_code | input | 7 | High-speed frequency-range code |
| cfg_clk_mhz | input | 8 | Configuration clock frequency in MHz (17 to 32) |
| wr_valid | output | 1 | Register write offered |
| wr_ready | input | 1 | Register bus accepts the write |
| wr_addr | output | ADDR_W | Register address |
| wr_data | output | 32 | Register data |
| ref_clk_en | output | 1 | PHY reference clock enable |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
A request sampled at a clock edge raises busy and the first wr_valid right after that edge. With ready high, the first write is accepted on the next edge. After that, each write either follows its predecessor by one cycle or by its wait plus one. done appears one cycle after the last accept. The bench logs every transfer half a cycle before the edge that completes it, together with a cycle number. It then checks the order, the data and the exact spacing from these logs, and it reads done and ref_clk_en at the same mid-cycle points. Under back-pressure the spacing checks relax to lower bounds, while the data and order checks stay exact.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  localparam int DATA_W = 32;

  // Control word fields decoded by the PHY
  localparam logic [1:0] CLKSEL_GEN  = 2'd1;
  localparam int         CLKSEL_LSB  = 6;
  localparam int         HS_LSB      = 8;
  localparam int         UPD_BIT     = 17;
  localparam int         SHCLR_BIT   = 18;

  // Divider word fields
  localparam int         R0_N_LSB    = 10;
  localparam int         R0_VCO_LSB  = 14;
  localparam int         R0_PROP_LSB = 20;

  // Charge-pump word
  localparam logic [1:0] GMP_CODE    = 2'd1;
  localparam logic [6:0] CPBIAS_CODE = 7'h10;
  localparam int         CPBIAS_LSB  = 2;

  localparam logic [7:0] CFG_MHZ_OFS = 8'd17;

  localparam logic [DATA_W-1:0] SEL_WORD = DATA_W'(CLKSEL_GEN) << CLKSEL_LSB;

  typedef struct packed {
    logic [9:0] m;
    logic [4:0] n;
    logic [5:0] vco;
    logic [5:0] prop;
    logic [6:0] hs;
    logic [7:0] cfg_mhz;
  } pll_op_t;

  typedef enum logic [1:0] {RS_CTRL, RS_DIV, RS_CP} reg_sel_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SEL, ST_SEL_T, ST_SHSET, ST_SHSET_T, ST_SHEND,
    ST_PROG, ST_DIV, ST_CP, ST_REF_T, ST_UPD, ST_UPD_T, ST_UPDCLR,
    ST_ZCTRL, ST_ZDIV, ST_ZCP
  } seq_st_e;
endpackage

// File: rtl/pll_word_pack.sv
module pll_word_pack
  import pll_seq_pkg::*;
(
  input  pll_op_t            op,
  output logic [DATA_W-1:0]  ctrl_prog,
  output logic [DATA_W-1:0]  div_word,
  output logic [DATA_W-1:0]  cp_word
);
  logic [7:0] mhz_diff;
  logic [5:0] cfr;
  logic [9:0] m_code;
  logic [3:0] n_code;
  logic [4:0] n_dec;

  always_comb begin
    mhz_diff  = op.cfg_mhz - CFG_MHZ_OFS;
    cfr       = {mhz_diff[3:0], 2'b00};
    m_code    = op.m - 10'd2;
    n_dec     = op.n - 5'd1;
    n_code    = n_dec[3:0];
    ctrl_prog = SEL_WORD | DATA_W'(cfr) | (DATA_W'(op.hs) << HS_LSB);
    div_word  = DATA_W'(m_code)
              | (DATA_W'(n_code)  << R0_N_LSB)
              | (DATA_W'(op.vco)  << R0_VCO_LSB)
              | (DATA_W'(op.prop) << R0_PROP_LSB);
    cp_word   = DATA_W'(GMP_CODE) | (DATA_W'(CPBIAS_CODE) << CPBIAS_LSB);
  end
endmodule

// File: rtl/pll_wait_timer.sv
module pll_wait_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign last = (cnt_q == CNT_W'(1));

  // R4: a new wait only starts once the previous one has run out
  p_reload_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (cnt_q == '0));
endmodule

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl
  import pll_seq_pkg::*;
#(
  parameter int SEL_WAIT = 4,
  parameter int CLR_WAIT = 2,
  parameter int REF_WAIT = 1000,
  parameter int UPD_WAIT = 400,
  parameter int CNT_W    = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              clear_req,
  input  logic              pwroff_req,
  input  logic [DATA_W-1:0] ctrl_prog,
  input  logic [DATA_W-1:0] div_word,
  input  logic [DATA_W-1:0] cp_word,
  input  logic              wr_ready,
  output logic              wr_valid,
  output reg_sel_e          reg_sel,
  output logic [DATA_W-1:0] wr_data,
  output logic              ref_clk_en,
  output logic              busy,
  output logic              done,
  output logic              op_take
);
  localparam logic [CNT_W-1:0] SEL_L = CNT_W'(SEL_WAIT);
  localparam logic [CNT_W-1:0] CLR_L = CNT_W'(CLR_WAIT);
  localparam logic [CNT_W-1:0] REF_L = CNT_W'(REF_WAIT);
  localparam logic [CNT_W-1:0] UPD_L = CNT_W'(UPD_WAIT);
  localparam logic [DATA_W-1:0] UPD_MASK = DATA_W'(1) << UPD_BIT;
  localparam logic [DATA_W-1:0] SHC_MASK = DATA_W'(1) << SHCLR_BIT;

  seq_st_e           state_q;
  logic              pwr_q;
  logic [DATA_W-1:0] shadow_q;   // last control word written, for read-modify-write
  logic              accept;
  logic              t_load;
  logic [CNT_W-1:0]  t_val;
  logic              t_last;

  always_comb begin
    wr_valid = 1'b1;
    reg_sel  = RS_CTRL;
    wr_data  = '0;
    unique case (state_q)
      ST_SEL:    wr_data = SEL_WORD;
      ST_SHSET:  wr_data = SEL_WORD | SHC_MASK;
      ST_SHEND:  wr_data = SEL_WORD;
      ST_PROG:   wr_data = ctrl_prog;
      ST_DIV:    begin reg_sel = RS_DIV; wr_data = div_word; end
      ST_CP:     begin reg_sel = RS_CP;  wr_data = cp_word;  end
      ST_UPD:    wr_data = shadow_q | UPD_MASK;
      ST_UPDCLR: wr_data = shadow_q & ~UPD_MASK;
      ST_ZCTRL:  wr_data = '0;
      ST_ZDIV:   reg_sel = RS_DIV;
      ST_ZCP:    reg_sel = RS_CP;
      default:   wr_valid = 1'b0;
    endcase
  end

  assign accept  = wr_valid && wr_ready;
  assign busy    = (state_q != ST_IDLE);
  assign op_take = (state_q == ST_IDLE) && start && !clear_req && !pwroff_req;

  always_comb begin
    t_load = 1'b0;
    t_val  = '0;
    if (accept) begin
      unique case (state_q)
        ST_SEL:   begin t_load = 1'b1; t_val = SEL_L; end
        ST_SHSET: begin t_load = 1'b1; t_val = CLR_L; end
        ST_CP:    begin t_load = 1'b1; t_val = REF_L; end
        ST_UPD:   begin t_load = 1'b1; t_val = UPD_L; end
        default:  ;
      endcase
    end
  end

  pll_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .last     (t_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      pwr_q      <= 1'b0;
      shadow_q   <= '0;
      ref_clk_en <= 1'b0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept && reg_sel == RS_CTRL) shadow_q <= wr_data;
      unique case (state_q)
        ST_IDLE: begin
          if (pwroff_req) begin
            pwr_q <= 1'b1; state_q <= ST_ZCTRL;
          end else if (clear_req) begin
            pwr_q <= 1'b0; state_q <= ST_ZCTRL;
          end else if (start) begin
            state_q <= ST_SEL;
          end
        end
        ST_SEL:     if (accept) state_q <= ST_SEL_T;
        ST_SEL_T:   if (t_last) state_q <= ST_SHSET;
        ST_SHSET:   if (accept) state_q <= ST_SHSET_T;
        ST_SHSET_T: if (t_last) state_q <= ST_SHEND;
        ST_SHEND:   if (accept) state_q <= ST_PROG;
        ST_PROG:    if (accept) state_q <= ST_DIV;
        ST_DIV:     if (accept) state_q <= ST_CP;
        ST_CP: if (accept) begin
          ref_clk_en <= 1'b1;
          state_q    <= ST_REF_T;
        end
        ST_REF_T:   if (t_last) state_q <= ST_UPD;
        ST_UPD:     if (accept) state_q <= ST_UPD_T;
        ST_UPD_T:   if (t_last) state_q <= ST_UPDCLR;
        ST_UPDCLR: if (accept) begin
          done    <= 1'b1;
          state_q <= ST_IDLE;
        end
        ST_ZCTRL:   if (accept) state_q <= ST_ZDIV;
        ST_ZDIV:    if (accept) state_q <= ST_ZCP;
        ST_ZCP: if (accept) begin
          if (pwr_q) ref_clk_en <= 1'b0;
          done    <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Cycles elapsed since the last accepted write (checking aid)
  logic [CNT_W:0] gap_q;
  always_ff @(posedge clk) begin
    if (!rst_n)                 gap_q <= '0;
    else if (accept)            gap_q <= '0;
    else if (gap_q != '1)       gap_q <= gap_q + 1'b1;
  end

  p_sel_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && state_q == ST_SHSET) |-> (gap_q >= (CNT_W+1)'(SEL_WAIT)));
  p_shclr_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && state_q == ST_SHEND) |-> (gap_q >= (CNT_W+1)'(CLR_WAIT)));
  p_ref_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && state_q == ST_UPD) |-> (ref_clk_en && gap_q >= (CNT_W+1)'(REF_WAIT)));
  p_upd_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && state_q == ST_UPDCLR) |-> (gap_q >= (CNT_W+1)'(UPD_WAIT)));
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data) && $stable(reg_sel)));
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_busy_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
endmodule

// File: rtl/pll_cfg_seq.sv
module pll_cfg_seq
  import pll_seq_pkg::*;
#(
  parameter int              ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h4C,
  parameter logic [ADDR_W-1:0] DIV_ADDR  = 8'h50,
  parameter logic [ADDR_W-1:0] CP_ADDR   = 8'h54,
  parameter int              SEL_WAIT  = 4,
  parameter int              CLR_WAIT  = 2,
  parameter int              REF_WAIT  = 1000,
  parameter int              UPD_WAIT  = 400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              clear_req,
  input  logic              pwroff_req,
  input  logic [9:0]        m_val,
  input  logic [4:0]        n_val,
  input  logic [5:0]        vco_code,
  input  logic [5:0]        prop_code,
  input  logic [6:0]        hsrange_code,
  input  logic [7:0]        cfg_clk_mhz,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [31:0]       wr_data,
  output logic              ref_clk_en,
  output logic              busy,
  output logic              done
);
  localparam int MAX_A    = (SEL_WAIT > CLR_WAIT) ? SEL_WAIT : CLR_WAIT;
  localparam int MAX_B    = (REF_WAIT > UPD_WAIT) ? REF_WAIT : UPD_WAIT;
  localparam int MAX_WAIT = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);

  pll_op_t           op_q;
  logic              op_take;
  logic [DATA_W-1:0] ctrl_prog, div_word, cp_word;
  reg_sel_e          reg_sel;

  always_ff @(posedge clk) begin
    if (!rst_n)       op_q <= '0;
    else if (op_take) op_q <= '{m: m_val, n: n_val, vco: vco_code, prop: prop_code,
                                hs: hsrange_code, cfg_mhz: cfg_clk_mhz};
  end

  pll_word_pack u_pack (
    .op        (op_q),
    .ctrl_prog (ctrl_prog),
    .div_word  (div_word),
    .cp_word   (cp_word)
  );

  pll_seq_ctrl #(
    .SEL_WAIT (SEL_WAIT),
    .CLR_WAIT (CLR_WAIT),
    .REF_WAIT (REF_WAIT),
    .UPD_WAIT (UPD_WAIT),
    .CNT_W    (CNT_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .clear_req  (clear_req),
    .pwroff_req (pwroff_req),
    .ctrl_prog  (ctrl_prog),
    .div_word   (div_word),
    .cp_word    (cp_word),
    .wr_ready   (wr_ready),
    .wr_valid   (wr_valid),
    .reg_sel    (reg_sel),
    .wr_data    (wr_data),
    .ref_clk_en (ref_clk_en),
    .busy       (busy),
    .done       (done),
    .op_take    (op_take)
  );

  always_comb begin
    unique case (reg_sel)
      RS_DIV:  wr_addr = DIV_ADDR;
      RS_CP:   wr_addr = CP_ADDR;
      default: wr_addr = CTRL_ADDR;
    endcase
  end
endmodule

// File: tb/sim_pll_cfg_seq.sv
`timescale 1ns/1ps
module sim_pll_cfg_seq;
  localparam int SEL_W = 4;
  localparam int CLR_W = 2;
  localparam int REF_W = 1000;
  localparam int UPD_W = 400;
  localparam logic [7:0] A_CTRL = 8'h4C;
  localparam logic [7:0] A_DIV  = 8'h50;
  localparam logic [7:0] A_CP   = 8'h54;

  // {m[41:32], n[31:27], vco[26:21], prop[20:15], hs[14:8], cfg_mhz[7:0]}
  localparam logic [41:0] VEC [5] = '{
    {10'd64,  5'd1,  6'h3f, 6'h0d, 7'h00, 8'd24},
    {10'd625, 5'd16, 6'h01, 6'h0e, 7'h49, 8'd32},
    {10'd300, 5'd4,  6'h0f, 6'h0d, 7'h35, 8'd17},
    {10'd125, 5'd2,  6'h27, 6'h0d, 7'h13, 8'd20},
    {10'd480, 5'd8,  6'h17, 6'h0d, 7'h1c, 8'd27}
  };

  logic clk = 0, rst_n = 0;
  logic start = 0, clear_req = 0, pwroff_req = 0;
  logic [9:0] m_val = 0; logic [4:0] n_val = 0;
  logic [5:0] vco_code = 0, prop_code = 0; logic [6:0] hsrange_code = 0;
  logic [7:0] cfg_clk_mhz = 0;
  logic wr_valid, wr_ready = 1;
  logic [7:0] wr_addr; logic [31:0] wr_data;
  logic ref_clk_en, busy, done;

  always #2.5 clk = ~clk;

  pll_cfg_seq #(.ADDR_W(8), .CTRL_ADDR(A_CTRL), .DIV_ADDR(A_DIV), .CP_ADDR(A_CP),
    .SEL_WAIT(SEL_W), .CLR_WAIT(CLR_W), .REF_WAIT(REF_W), .UPD_WAIT(UPD_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .clear_req(clear_req),
    .pwroff_req(pwroff_req), .m_val(m_val), .n_val(n_val), .vco_code(vco_code),
    .prop_code(prop_code), .hsrange_code(hsrange_code), .cfg_clk_mhz(cfg_clk_mhz),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .ref_clk_en(ref_clk_en), .busy(busy), .done(done));

  int nchk = 0, nfail = 0, cyc = 0, nw = 0, dcnt = 0, dcyc = 0;
  bit dbusy, dref, bp_mode = 0;
  int bp_cnt = 0;
  logic [7:0]  la [32];
  logic [31:0] ld [32];
  int          lc [32];
  bit          lr [32];
  bit          lb [32];

  // Transfer log, sampled mid-cycle before the completing edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n && wr_valid && wr_ready && nw < 32) begin
      la[nw] = wr_addr; ld[nw] = wr_data; lc[nw] = cyc;
      lr[nw] = ref_clk_en; lb[nw] = busy; nw++;
    end
    if (rst_n && done) begin dcnt++; dcyc = cyc; dbusy = busy; dref = ref_clk_en; end
  end

  always @(posedge clk) begin
    #1;
    bp_cnt++;
    wr_ready = bp_mode ? ((bp_cnt % 3) != 0) : 1'b1;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic set_ops(input logic [41:0] v);
    m_val = v[41:32]; n_val = v[31:27]; vco_code = v[26:21];
    prop_code = v[20:15]; hsrange_code = v[14:8]; cfg_clk_mhz = v[7:0];
  endtask

  task automatic req(input bit s, input bit c, input bit p);
    nw = 0; dcnt = 0;
    @(posedge clk); #1;
    start = s; clear_req = c; pwroff_req = p;
    @(posedge clk); #1;
    start = 0; clear_req = 0; pwroff_req = 0;
  endtask

  task automatic wait_done();
    for (int k = 0; k < 20000 && dcnt == 0; k++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [31:0] exp_prog(input logic [41:0] v);
    logic [7:0] d;
    d = v[7:0] - 8'd17;
    return 32'h40 | {24'd0, d[3:0], 2'b00} | ({25'd0, v[14:8]} << 8);
  endfunction

  function automatic logic [31:0] exp_div(input logic [41:0] v);
    logic [9:0] mm; logic [4:0] nn;
    mm = v[41:32] - 10'd2; nn = v[31:27] - 5'd1;
    return {22'd0, mm} | ({28'd0, nn[3:0]} << 10) | ({26'd0, v[26:21]} << 14)
         | ({26'd0, v[20:15]} << 20);
  endfunction

  task automatic check_cfg(input logic [41:0] v, input bit exact);
    logic [7:0]  ea [8];
    logic [31:0] ed [8];
    string rq [8];
    ea = '{A_CTRL, A_CTRL, A_CTRL, A_CTRL, A_DIV, A_CP, A_CTRL, A_CTRL};
    ed = '{32'h40, 32'h40040, 32'h40, exp_prog(v), exp_div(v), 32'h41,
           exp_prog(v) | 32'h20000, exp_prog(v)};
    rq = '{"R2 clksel", "R2 shadow set", "R2 shadow end", "R3 ctrl word",
           "R3 div word", "R3 cp word", "R6 update set", "R6 update clear"};
    check(nw == 8, "R2 write count", nw, 8);
    if (nw == 8) begin
      for (int i = 0; i < 8; i++) begin
        check(la[i] == ea[i], rq[i], {24'd0, la[i]}, {24'd0, ea[i]});
        check(ld[i] == ed[i], rq[i], ld[i], ed[i]);
        check(lb[i], "R8 busy during write", lb[i], 1);
      end
      if (exact) begin
        check(lc[1]-lc[0] == SEL_W+1, "R4 select gap", lc[1]-lc[0], SEL_W+1);
        check(lc[2]-lc[1] == CLR_W+1, "R4 shadow pulse", lc[2]-lc[1], CLR_W+1);
        check(lc[6]-lc[5] == REF_W+1, "R5 ref settle", lc[6]-lc[5], REF_W+1);
        check(lc[7]-lc[6] == UPD_W+1, "R6 update hold", lc[7]-lc[6], UPD_W+1);
      end else begin
        check(lc[1]-lc[0] >= SEL_W+1, "R4 select gap min", lc[1]-lc[0], SEL_W+1);
        check(lc[2]-lc[1] >= CLR_W+1, "R4 shadow pulse min", lc[2]-lc[1], CLR_W+1);
        check(lc[6]-lc[5] >= REF_W+1, "R5 ref settle min", lc[6]-lc[5], REF_W+1);
        check(lc[7]-lc[6] >= UPD_W+1, "R6 update hold min", lc[7]-lc[6], UPD_W+1);
      end
      check(lr[6] && lr[7], "R5 ref enabled before update", {lr[6], lr[7]}, 2'b11);
      check(dcnt == 1 && dcyc == lc[7] + 1, "R8 done timing", dcyc, lc[7] + 1);
      check(!dbusy, "R8 busy low at done", dbusy, 0);
    end
  endtask

  task automatic check_zero(input bit exp_ref, input string rq);
    check(nw == 3, rq, nw, 3);
    if (nw == 3) begin
      check(la[0] == A_CTRL && la[1] == A_DIV && la[2] == A_CP, rq,
            {la[0], la[1], la[2]}, {A_CTRL, A_DIV, A_CP});
      check(ld[0] == 0 && ld[1] == 0 && ld[2] == 0, rq, ld[0] | ld[1] | ld[2], 0);
      check(dcnt == 1 && dcyc == lc[2] + 1, "R8 done after clear", dcyc, lc[2] + 1);
    end
    check(dref == exp_ref && ref_clk_en == exp_ref, rq, ref_clk_en, exp_ref);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired act=%0d exp=done", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(!wr_valid && !busy && !done && !ref_clk_en, "R1 in reset",
          {wr_valid, busy, done, ref_clk_en}, 0);
    @(posedge clk); #1; rst_n = 1;
    repeat (4) @(negedge clk);
    check(!wr_valid && !busy && !done && !ref_clk_en, "R1 after reset",
          {wr_valid, busy, done, ref_clk_en}, 0);

    // First configure: ref enable must still be low at write six (R5)
    set_ops(VEC[0]); req(1, 0, 0); wait_done();
    check_cfg(VEC[0], 1);
    check(nw == 8 && !lr[5], "R5 ref off before cp write", lr[5], 0);

    // Table of operand vectors, ready held high
    for (int i = 1; i < 5; i++) begin
      set_ops(VEC[i]); req(1, 0, 0); wait_done();
      check_cfg(VEC[i], 1);
    end

    // R7: back-pressure on the write port
    bp_mode = 1;
    set_ops(VEC[3]); req(1, 0, 0); wait_done();
    check_cfg(VEC[3], 0);
    bp_mode = 0;

    // R9: operand change and second request while busy are ignored
    set_ops(VEC[2]); req(1, 0, 0);
    for (int k = 0; k < 100 && nw < 3; k++) @(negedge clk);
    set_ops(VEC[1]);
    @(posedge clk); #1; start = 1; clear_req = 1;
    @(posedge clk); #1; start = 0; clear_req = 0;
    wait_done();
    check(nw == 8, "R9 requests while busy ignored", nw, 8);
    check_cfg(VEC[2], 1);

    // R10: clear keeps the reference clock on
    req(0, 1, 0); wait_done();
    check_zero(1'b1, "R10 clear sequence");

    // R11: power-off
    req(0, 0, 1); wait_done();
    check_zero(1'b0, "R11 power-off sequence");

    // R12: coincident requests
    set_ops(VEC[4]); req(1, 0, 0); wait_done();
    check_cfg(VEC[4], 1);
    req(1, 1, 1); wait_done();
    check_zero(1'b0, "R12 power-off wins");
    set_ops(VEC[0]); req(1, 0, 0); wait_done();
    req(1, 1, 0); wait_done();
    check_zero(1'b1, "R12 clear wins over configure");

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule